// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block is the front end for four external interrupt lines. Each input pin is first brought into the clock domain through a synchronizer. The synchronized value is then compared with a held copy of the previous sample. A 2-bit mode field per line decides which condition raises a request: a low level, any change, a falling edge or a rising edge.

In the three edge-type modes, a detection sets a sticky flag. The flag holds until an acknowledge strobe for that line arrives, or until software writes a one to the flag bit. In low-level mode no flag is kept, and the request follows the pin for as long as the pin stays low.

A request reaches the outputs only when its per-line enable bit and the global interrupt-enable input are both high. The outputs give one registered request per line plus a registered OR of all of them. Software reaches the mode, enable and flag registers over a small synchronous read/write bus.

Top module: `ext_irq_sense`

## Requirements
- R1: After synchronous reset, the mode register (address 0), the enable register (address 1) and the flag register (address 2) read 0, and `irq_o` and `irq_any_o` are 0.
- R2: The mode register holds 2 bits per line, with line n at bits [2n+1:2n], and it reads back what was written. The encoding is 00 = low level, 01 = any change, 10 = falling edge, 11 = rising edge.
- R3: Bits 3..0 of the enable register are the per-line enables. Bits 7..4 always read 0, and writing them has no effect.
- R4: In low-level mode, `irq_o[n]` is high while the synchronized pin is low. It becomes valid two clock edges after the pin is first sampled low and drops in the same way once the pin goes high. The flag bit for that line reads 0.
- R5: In any-change mode, each transition of the pin sets flag bit n (flag register bit n) and raises `irq_o[n]` until the flag is cleared.
- R6: In falling-edge mode, a high-to-low transition sets the flag. A low-to-high transition does not.
- R7: In rising-edge mode, a low-to-high transition sets the flag. A high-to-low transition does not.
- R8: A pin level held for two or more clock periods is always detected.
- R9: `irq_o[n]` is high only when enable bit n and `gie_i` were both 1 on the previous edge. Flags still latch while a line is disabled, and they raise the request once the line is enabled.
- R10: A flag clears when `ack_i[n]` is high for a cycle, or when a one is written to bit n of address 2. If a detection and a clear fall in the same cycle, the flag stays set.
- R11: `irq_any_o` equals the OR of all bits of `irq_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_CH | Asynchronous external interrupt pins |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | NUM_CH | Per-line flag clear strobes |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after `rd_en_i` |
| irq_o | output | NUM_CH | Registered per-line requests |
| irq_any_o | output | 1 | Registered OR of the per-line requests |

## Verification
The critical collision happens when a fresh edge detection and a flag clear land in the same cycle. The clear can come from an acknowledge strobe or from a write-one to the flag register. A directed case drives the acknowledge exactly in the cycle in which the delayed pin sample differs from the previous one, and it expects the flag to read back as 1. The random phase mixes pin toggles, acknowledges and flag writes freely, and it judges every cycle against a bench model in which set takes priority over clear.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_mode_e;

  localparam int REG_SENSE  = 0;
  localparam int REG_ENABLE = 1;
  localparam int REG_FLAG   = 2;
endpackage

// File: rtl/eis_pin_sync.sv
module eis_pin_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [WIDTH-1:0]             prev_q;

  // pins idle high; reset to that level avoids a false edge after reset
  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '1;
    else     chain_q[0] <= pin_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= '1;
        else     chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign cur_o  = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/eis_channel.sv
module eis_channel
  import ext_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  sense_mode_e mode_i,
  input  logic        cur_i,
  input  logic        prev_i,
  input  logic        clr_i,
  output logic        req_o,
  output logic        flag_o
);
  logic hit;
  logic flag_q;

  always_comb begin
    unique case (mode_i)
      SENSE_ANY:  hit = cur_i ^ prev_i;
      SENSE_FALL: hit = prev_i & ~cur_i;
      SENSE_RISE: hit = ~prev_i & cur_i;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                     flag_q <= 1'b0;
    else if (mode_i == SENSE_LOW) flag_q <= 1'b0;
    else if (hit)                flag_q <= 1'b1;
    else if (clr_i)              flag_q <= 1'b0;
  end

  assign req_o  = (mode_i == SENSE_LOW) ? ~cur_i : flag_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/eis_regfile.sv
module eis_regfile
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [NUM_CH-1:0]   flag_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [2*NUM_CH-1:0] sense_o,
  output logic [NUM_CH-1:0]   enable_o,
  output logic [NUM_CH-1:0]   flag_wclr_o
);
  localparam int SENSE_W = 2 * NUM_CH;

  logic [SENSE_W-1:0] sense_q;
  logic [NUM_CH-1:0]  enable_q;
  logic [DATA_W-1:0]  rdata_q;
  logic [DATA_W-1:0]  rd_mux;

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(REG_SENSE))  rd_mux[SENSE_W-1:0] = sense_q;
    if (addr_i == ADDR_W'(REG_ENABLE)) rd_mux[NUM_CH-1:0]  = enable_q;
    if (addr_i == ADDR_W'(REG_FLAG))   rd_mux[NUM_CH-1:0]  = flag_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q  <= '0;
      enable_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (wr_en_i && addr_i == ADDR_W'(REG_SENSE))  sense_q  <= wdata_i[SENSE_W-1:0];
      if (wr_en_i && addr_i == ADDR_W'(REG_ENABLE)) enable_q <= wdata_i[NUM_CH-1:0];
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign flag_wclr_o = (wr_en_i && addr_i == ADDR_W'(REG_FLAG)) ? wdata_i[NUM_CH-1:0] : '0;
  assign sense_o     = sense_q;
  assign enable_o    = enable_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              gie_i,
  input  logic [NUM_CH-1:0] ack_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic              irq_any_o
);
  localparam int SENSE_W = 2 * NUM_CH;

  logic [NUM_CH-1:0]  cur, prev, req, flag_vec, wclr, enable;
  logic [SENSE_W-1:0] sense;
  logic [NUM_CH-1:0]  gated;
  logic [NUM_CH-1:0]  irq_q;
  logic               any_q;

  eis_pin_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .cur_o(cur), .prev_o(prev)
  );

  eis_regfile #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .flag_i(flag_vec),
    .rdata_o(rdata_o), .sense_o(sense), .enable_o(enable), .flag_wclr_o(wclr)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      eis_channel u_ch (
        .clk(clk), .rst(rst),
        .mode_i(sense_mode_e'(sense[2*g +: 2])),
        .cur_i(cur[g]), .prev_i(prev[g]),
        .clr_i(ack_i[g] | wclr[g]),
        .req_o(req[g]), .flag_o(flag_vec[g])
      );
    end
  endgenerate

  assign gated = req & enable & {NUM_CH{gie_i}};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= '0;
      any_q <= 1'b0;
    end else begin
      irq_q <= gated;
      any_q <= |gated;
    end
  end

  assign irq_o     = irq_q;
  assign irq_any_o = any_q;
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                gie_i,
  input logic                rd_en_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [NUM_CH-1:0]   irq_o,
  input logic                irq_any_o,
  input logic [NUM_CH-1:0]   flag_vec,
  input logic [2*NUM_CH-1:0] sense
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_o == '0 && !irq_any_o));

  // R9
  gie_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (|irq_o) |-> $past(gie_i));

  // R11
  any_or_chk: assert property (@(posedge clk) disable iff (rst)
    irq_any_o == (|irq_o));

  // R3
  resv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en_i) && $past(addr_i) == ADDR_W'(1)) |-> (rdata_o[DATA_W-1:NUM_CH] == '0));

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_lvl
      // R4
      level_noflag_chk: assert property (@(posedge clk) disable iff (rst)
        (sense[2*g +: 2] == 2'b00) |=> !flag_vec[g]);
    end
  endgenerate
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .gie_i(gie_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .irq_any_o(irq_any_o),
  .flag_vec(flag_vec), .sense(sense)
);

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;
  localparam int NCH = 4;
  localparam int DW  = 8;
  localparam int AW  = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] pin = '1;
  logic           gie = 1'b0;
  logic [NCH-1:0] ack = '0;
  logic           wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;
  logic [NCH-1:0] irq;
  logic           irq_any;

  int checks = 0, errors = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  ext_irq_sense u_ext_irq_sense (
    .clk(clk), .rst(rst), .pin_i(pin), .gie_i(gie), .ack_i(ack),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .irq_any_o(irq_any)
  );

  // reference model
  logic [NCH-1:0]   m_s1, m_s2, m_prev, m_flag, m_en, m_irq;
  logic [2*NCH-1:0] m_sense;

  function automatic logic [NCH-1:0] f_flag_next(logic [2*NCH-1:0] sn, logic [NCH-1:0] cur,
      logic [NCH-1:0] prv, logic [NCH-1:0] fl, logic [NCH-1:0] clr);
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) begin
      logic det;
      case (sn[2*c +: 2])
        2'b01:   det = cur[c] ^ prv[c];
        2'b10:   det = prv[c] & ~cur[c];
        2'b11:   det = ~prv[c] & cur[c];
        default: det = 1'b0;
      endcase
      if (sn[2*c +: 2] == 2'b00) r[c] = 1'b0;
      else if (det)              r[c] = 1'b1;
      else if (clr[c])           r[c] = 1'b0;
      else                       r[c] = fl[c];
    end
    return r;
  endfunction

  function automatic logic [NCH-1:0] f_req(logic [2*NCH-1:0] sn, logic [NCH-1:0] cur, logic [NCH-1:0] fl);
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) r[c] = (sn[2*c +: 2] == 2'b00) ? ~cur[c] : fl[c];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= '1; m_s2 <= '1; m_prev <= '1;
      m_flag <= '0; m_en <= '0; m_irq <= '0; m_sense <= '0;
    end else begin
      logic [NCH-1:0] clr;
      clr = ack | ((wr_en && addr == 2) ? wdata[NCH-1:0] : '0);
      m_s1 <= pin; m_s2 <= m_s1; m_prev <= m_s2;
      m_flag <= f_flag_next(m_sense, m_s2, m_prev, m_flag, clr);
      m_irq <= f_req(m_sense, m_s2, m_flag) & m_en & {NCH{gie}};
      if (wr_en && addr == 0) m_sense <= wdata;
      if (wr_en && addr == 1) m_en <= wdata[NCH-1:0];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // R9 / R11 every-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R9 irq_o", irq, m_irq);
      chk("R11 irq_any_o", irq_any, |m_irq);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string tag, int a, logic [DW-1:0] exp);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic rd_model(int a);
    logic [DW-1:0] e;
    e = '0;
    if (a == 0) e = m_sense;
    if (a == 1) e[NCH-1:0] = m_en;
    if (a == 2) e[NCH-1:0] = m_flag;
    rd("R2 random readback", a, e);
  endtask

  initial begin
    cyc(5);
    chk("R1 irq after reset", irq, 0);
    chk("R1 any after reset", irq_any, 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    cyc(2);
    rd("R1 sense reset", 0, 8'h00);
    rd("R1 enable reset", 1, 8'h00);
    rd("R1 flag reset", 2, 8'h00);

    // line3 rise, line2 fall, line1 any, line0 low
    wr(0, 8'hE4);
    rd("R2 sense readback", 0, 8'hE4);
    wr(1, 8'hFF);
    rd("R3 reserved bits zero", 1, 8'h0F);
    gie = 1'b1;

    // R4 low level
    pin[0] = 1'b0; cyc(3);
    chk("R4 level asserted", irq[0], 1);
    rd("R4 no flag in level mode", 2, 8'h00);
    pin[0] = 1'b1; cyc(3);
    chk("R4 level released", irq[0], 0);

    // R5 any change, R10 ack clear
    pin[1] = 1'b0; cyc(4);
    chk("R5 toggle low sets", irq[1], 1);
    chk("R11 any follows", irq_any, 1);
    ack[1] = 1'b1; cyc(1); ack[1] = 1'b0; cyc(2);
    chk("R10 ack clears", irq[1], 0);
    pin[1] = 1'b1; cyc(4);
    rd("R5 toggle high sets flag", 2, 8'h02);
    wr(2, 8'h02); cyc(2);
    rd("R10 write-one clears", 2, 8'h00);

    // R6 falling edge, with a two-cycle low pulse (R8)
    pin[2] = 1'b0; cyc(2); pin[2] = 1'b1; cyc(4);
    rd("R8 short pulse caught", 2, 8'h04);
    wr(2, 8'h04); cyc(1);
    pin[2] = 1'b0; cyc(4);
    wr(2, 8'h04); cyc(1);
    pin[2] = 1'b1; cyc(4);
    rd("R6 rise ignored in fall mode", 2, 8'h00);

    // R7 rising edge
    pin[3] = 1'b0; cyc(4);
    rd("R7 fall ignored in rise mode", 2, 8'h00);
    pin[3] = 1'b1; cyc(4);
    rd("R7 rise sets flag", 2, 8'h08);
    chk("R7 irq raised", irq[3], 1);

    // R9 gating
    gie = 1'b0; cyc(2);
    chk("R9 gie low masks", irq, 0);
    rd("R9 flag kept while masked", 2, 8'h08);
    gie = 1'b1; cyc(2);
    chk("R9 gie restores", irq[3], 1);
    wr(2, 8'h08);
    wr(1, 8'h00);
    pin[1] = 1'b0; cyc(4);
    chk("R9 disabled line silent", irq[1], 0);
    rd("R9 flag latches while disabled", 2, 8'h02);
    wr(1, 8'h0F); cyc(2);
    chk("R9 enable exposes flag", irq[1], 1);
    wr(2, 8'h02); cyc(2);

    // R10 set wins over simultaneous ack
    pin[1] = 1'b1; cyc(2);
    ack[1] = 1'b1; cyc(1); ack[1] = 1'b0;
    cyc(1);
    rd("R10 set beats ack", 2, 8'h02);
    wr(2, 8'h02); cyc(2);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 30)      pin = NCH'($urandom);
      ack = ($urandom_range(0, 9) == 0) ? NCH'($urandom) : '0;
      if (r >= 30 && r < 33) gie = ~gie;
      if (r == 40)      wr(0, DW'($urandom));
      else if (r == 41) wr(1, DW'($urandom));
      else if (r == 42) wr(2, DW'($urandom));
      else if (r >= 43 && r < 48) begin
        ack = '0;
        rd_model($urandom_range(0, 3));
      end else cyc(1);
    end
    ack = '0;
    cyc(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule